// File: doc/BRIEF.md
# Interrupt Vector Table with Unmask-Time Message Capture

This block keeps a small table of interrupt vectors in local flops. Each vector has a 64-bit message address, a 32-bit message data word and a control word that holds a mask bit. Software reads and writes the table one 32-bit word at a time through a simple register port, so a 64-bit address always takes two separate writes. Internal interrupt request lines set bits in a pending array. An unmasked vector with its pending bit set produces one posted-write message request, made of an address and a data word, on a valid/ready output.

The block watches every write to a control word. When a vector's mask bit goes from 1 to 0, the vector's current address and data words are copied into a private shadow set. Messages are always built from the shadow set and never from the live table. Rewriting the address or data of an unmasked vector therefore has no effect on what goes out until the vector is masked and unmasked again. The result never depends on the order in which software writes the halves of the address. A message already held in the output register when software masks its vector is still delivered. The block does not recall it.

Top module: `msix_shadow_ctrl`

## Requirements
- R1: After reset, every control word reads 1 (masked), every address and data word reads 0, the pending word reads 0 and `msg_valid` is 0.
- R2: Word index `4*v + f` selects vector v. Field f=0 is address bits 31:0, f=1 is address bits 63:32, f=2 is data, and f=3 is control, with the mask in bit 0 and bits 31:1 reading 0. Word index `4*NUM_VEC` is the read-only pending word, with bit v for vector v. Any other index reads 0. Writes to the pending word or to any other index beyond the table change nothing.
- R3: No message is ever loaded for a vector while its mask bit is 1. A request on a masked vector sets its pending bit instead.
- R4: A control write that clears a mask bit that was 1 copies that vector's address and data words, as they stood before the write, into its shadow set. Every message for that vector carries the shadowed values.
- R5: Writes to the address or data words of an unmasked vector change the table contents as read back, but not the messages sent. The new values are used only after a later mask-then-unmask sequence.
- R6: Register reads have no side effect on pending bits, the shadow set or messages.
- R7: A pulse on `irq_req[v]` sets pending bit v. When vector v is unmasked and pending, one message is loaded into the output register on the next free cycle, and pending bit v clears in that same cycle unless a new request arrives with it.
- R8: When several vectors are unmasked and pending, the lowest-numbered one is loaded first. One message is loaded per free output slot.
- R9: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` hold steady. A message already loaded is delivered even if its vector is masked afterwards.
- R10: A control write of mask 0 to a vector that is already unmasked does not refresh its shadow set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (5) | Word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | input | NUM_VEC (4) | Per-vector interrupt request pulses |
| msg_valid | output | 1 | Message request is valid |
| msg_ready | input | 1 | Output queue accepts the message |
| msg_addr | output | 64 | Message address from the shadow set |
| msg_data | output | 32 | Message data from the shadow set |

## Verification
The bench runs a behavioural model and compares it with the design on every clock while several stimulus patterns run. A request on a masked vector separates "held as pending" from "dropped" or "sent anyway". A rewrite of data while unmasked, followed by a request, separates capture at unmask from live lookup. A repeated mask-0 write separates edge capture from level capture. Requests on all vectors at once under back-pressure expose the service order and the hold behaviour. Masking a vector whose message already sits in the output register shows that the message is delivered and not withdrawn.

// File: rtl/msix_pkg.sv
package msix_pkg;
    // One vector's message content as stored in the table or the shadow set.
    typedef struct packed {
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] data;
    } msg_t;

    // Field selector: low two bits of the word index.
    typedef enum logic [1:0] {
        FLD_ADDR_LO = 2'd0,
        FLD_ADDR_HI = 2'd1,
        FLD_DATA    = 2'd2,
        FLD_CTRL    = 2'd3
    } fld_e;

    localparam int unsigned WORDS_PER_VEC = 4;
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int NV = 4,
    parameter int AW = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [31:0]            wdata,
    input  logic [NV-1:0]          pend,
    output logic [31:0]            rdata,
    output logic [NV-1:0]          mask_q,
    output msg_t [NV-1:0]          shd_q
);
    localparam int EW = AW - 2;

    typedef struct packed {
        msg_t [NV-1:0]  tbl;
        msg_t [NV-1:0]  shd;
        logic [NV-1:0]  mask;
    } tbl_st_t;

    tbl_st_t st_q, st_d;
    logic [EW-1:0] ent;
    fld_e          fld;

    assign ent = addr[AW-1:2];
    assign fld = fld_e'(addr[1:0]);

    // Next-state: table writes and shadow capture on a 1->0 mask edge.
    always_comb begin
        st_d = st_q;
        if (we) begin
            for (int i = 0; i < NV; i++) begin
                if (int'(ent) == i) begin
                    case (fld)
                        FLD_ADDR_LO: st_d.tbl[i].lo   = wdata;
                        FLD_ADDR_HI: st_d.tbl[i].hi   = wdata;
                        FLD_DATA:    st_d.tbl[i].data = wdata;
                        default: begin
                            if (st_q.mask[i] && !wdata[0])
                                st_d.shd[i] = st_q.tbl[i];
                            st_d.mask[i] = wdata[0];
                        end
                    endcase
                end
            end
        end
    end

    // Read path: table words, then the pending word, everything else zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NV; i++) begin
            if (int'(ent) == i) begin
                case (fld)
                    FLD_ADDR_LO: rdata = st_q.tbl[i].lo;
                    FLD_ADDR_HI: rdata = st_q.tbl[i].hi;
                    FLD_DATA:    rdata = st_q.tbl[i].data;
                    default:     rdata = {31'd0, st_q.mask[i]};
                endcase
            end
        end
        if (int'(ent) == NV && fld == FLD_ADDR_LO)
            rdata = 32'(pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
    assign shd_q  = st_q.shd;

    for (genvar g = 0; g < NV; g++) begin : g_chk
        // R4: an unmask edge captures the pre-write table contents.
        assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (we && int'(ent) == g && fld == FLD_CTRL && mask_q[g] && !wdata[0])
            |=> (shd_q[g] == $past(st_q.tbl[g])));
        // R10: without an unmask edge the shadow set holds.
        assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && int'(ent) == g && fld == FLD_CTRL && mask_q[g])
            |=> $stable(shd_q[g]));
    end
endmodule

// File: rtl/msix_pend_arb.sv
module msix_pend_arb #(
    parameter int NV = 4,
    parameter int IW = (NV > 1) ? $clog2(NV) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NV-1:0] irq,
    input  logic [NV-1:0] mask,
    input  logic          slot_free,
    output logic [NV-1:0] pend_q,
    output logic          grant_any,
    output logic [IW-1:0] grant_idx,
    output logic [NV-1:0] grant_vec
);
    logic [NV-1:0] pend_d;
    logic [NV-1:0] ready_v;

    always_comb begin
        ready_v   = pend_q & ~mask;
        grant_idx = '0;
        // Scan downward so the lowest ready index wins.
        for (int i = NV - 1; i >= 0; i--) begin
            if (ready_v[i]) grant_idx = IW'(i);
        end
        grant_any = slot_free && (|ready_v);
        grant_vec = grant_any ? (NV'(1) << grant_idx) : '0;
        pend_d    = (pend_q & ~grant_vec) | irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // R8: at most one vector is served per slot.
    assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    for (genvar g = 0; g < NV; g++) begin : g_clr
        // R7: a served vector's pending bit clears unless re-requested.
        assert_pend_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_vec[g] && !irq[g]) |=> !pend_q[g]);
        // R7: a request always leaves the pending bit set.
        assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |=> pend_q[g]);
    end
endmodule

// File: rtl/msix_msg_slot.sv
module msix_msg_slot
    import msix_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  msg_t load_msg,
    input  logic ready,
    output logic valid,
    output msg_t msg,
    output logic free
);
    typedef struct packed {
        logic v;
        msg_t m;
    } slot_st_t;

    slot_st_t st_q, st_d;

    always_comb begin
        free = !st_q.v || ready;
        st_d = st_q;
        if (load) begin
            st_d.v = 1'b1;
            st_d.m = load_msg;
        end else if (ready) begin
            st_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.v;
    assign msg   = st_q.m;

    // R9: a stalled message holds still.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(msg)));
    // R9: nothing is loaded over an unaccepted message.
    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> free);
endmodule

// File: rtl/msix_shadow_ctrl.sv
module msix_shadow_ctrl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 4,
    parameter int AW = $clog2(WORDS_PER_VEC * NUM_VEC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_VEC-1:0] irq_req,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);
    localparam int IW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic [NUM_VEC-1:0] mask_q;
    logic [NUM_VEC-1:0] pend_q;
    msg_t [NUM_VEC-1:0] shd_q;
    logic               slot_free;
    logic               grant_any;
    logic [IW-1:0]      grant_idx;
    logic [NUM_VEC-1:0] grant_vec;
    msg_t               sel_msg;
    msg_t               out_msg;

    msix_vec_table #(.NV(NUM_VEC), .AW(AW)) i_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pend   (pend_q),
        .rdata  (reg_rdata),
        .mask_q (mask_q),
        .shd_q  (shd_q)
    );

    msix_pend_arb #(.NV(NUM_VEC), .IW(IW)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq_req),
        .mask      (mask_q),
        .slot_free (slot_free),
        .pend_q    (pend_q),
        .grant_any (grant_any),
        .grant_idx (grant_idx),
        .grant_vec (grant_vec)
    );

    assign sel_msg = shd_q[grant_idx];

    msix_msg_slot i_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (grant_any),
        .load_msg (sel_msg),
        .ready    (msg_ready),
        .valid    (msg_valid),
        .msg      (out_msg),
        .free     (slot_free)
    );

    assign msg_addr = {out_msg.hi, out_msg.lo};
    assign msg_data = out_msg.data;

    // R3: a load never picks a vector whose table mask is set.
    assert_no_masked_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |-> ((grant_vec & mask_q) == '0));
    // R3: a load only serves a vector that was pending.
    assert_load_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant_any |-> ((grant_vec & ~pend_q) == '0));
endmodule

// File: tb/test_msix_shadow_ctrl.sv
`timescale 1ns/1ps
module test_msix_shadow_ctrl;
    localparam int NV = 4;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NV-1:0] irq_req = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    msix_shadow_ctrl #(.NUM_VEC(NV)) i_msix_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
        .msg_data(msg_data)
    );

    // Behavioural reference model.
    logic [31:0] m_lo[NV], m_hi[NV], m_dat[NV];
    logic [31:0] s_lo[NV], s_hi[NV], s_dat[NV];
    logic        m_mask[NV];
    logic [NV-1:0] m_pend;
    logic        m_v;
    logic [63:0] m_a;
    logic [31:0] m_d;
    logic [31:0] got_data[$];
    logic [63:0] got_addr[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NV; i++) begin
                m_lo[i] = 0; m_hi[i] = 0; m_dat[i] = 0;
                s_lo[i] = 0; s_hi[i] = 0; s_dat[i] = 0; m_mask[i] = 1;
            end
            m_pend = 0; m_v = 0; m_a = 0; m_d = 0;
        end else begin
            bit fire, free;
            int sel, e, f;
            fire = m_v && msg_ready;
            free = !m_v || fire;
            sel = -1;
            for (int i = NV - 1; i >= 0; i--) if (m_pend[i] && !m_mask[i]) sel = i;
            if (free && sel >= 0) begin
                m_v = 1; m_a = {s_hi[sel], s_lo[sel]}; m_d = s_dat[sel];
                m_pend[sel] = 0;
            end else if (fire) m_v = 0;
            m_pend = m_pend | irq_req;
            if (reg_we) begin
                e = int'(reg_addr) / 4; f = int'(reg_addr) % 4;
                if (e < NV) begin
                    if (f == 0) m_lo[e] = reg_wdata;
                    else if (f == 1) m_hi[e] = reg_wdata;
                    else if (f == 2) m_dat[e] = reg_wdata;
                    else begin
                        if (m_mask[e] && !reg_wdata[0]) begin
                            s_lo[e] = m_lo[e]; s_hi[e] = m_hi[e]; s_dat[e] = m_dat[e];
                        end
                        m_mask[e] = reg_wdata[0];
                    end
                end
            end
        end
    end

    function automatic logic [31:0] model_rd(input int a);
        int e, f;
        e = a / 4; f = a % 4;
        if (e < NV) begin
            if (f == 0) return m_lo[e];
            if (f == 1) return m_hi[e];
            if (f == 2) return m_dat[e];
            return {31'd0, m_mask[e]};
        end
        if (a == 4 * NV) return 32'(m_pend);
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Continuous comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 R7 R8 msg_valid", 64'(msg_valid), 64'(m_v));
            if (m_v) begin
                chk("R4 R5 msg_addr", msg_addr, m_a);
                chk("R4 R5 msg_data", 64'(msg_data), 64'(m_d));
            end
            chk("R2 R6 reg_rdata", 64'(reg_rdata), 64'(model_rd(int'(reg_addr))));
            if (msg_valid && msg_ready) begin
                got_data.push_back(msg_data);
                got_addr.push_back(msg_addr);
            end
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
        cyc();
        reg_we = 0;
    endtask

    task automatic pulse(input logic [NV-1:0] v);
        irq_req = v;
        cyc();
        irq_req = 0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        reg_addr = AW'(a);
        @(negedge clk);
        chk(tag, 64'(reg_rdata), 64'(exp));
        cyc();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc();
        // R1 reset state
        rd_chk("R1 ctrl0 masked", 3, 1);
        rd_chk("R1 ctrl3 masked", 15, 1);
        rd_chk("R1 lo1 zero", 4, 0);
        rd_chk("R1 pending zero", 16, 0);
        chk("R1 msg_valid", 64'(msg_valid), 0);

        // R2 field layout
        wr(0, 32'h1000_0000); wr(1, 32'h0000_0001); wr(2, 32'h0000_00A0);
        rd_chk("R2 lo0", 0, 32'h1000_0000);
        rd_chk("R2 hi0", 1, 32'h0000_0001);
        rd_chk("R2 data0", 2, 32'h0000_00A0);
        wr(16, 32'hF); wr(20, 32'h1234);
        rd_chk("R2 pending write ignored", 16, 0);
        rd_chk("R2 out of range", 20, 0);

        // R3 request while masked is held
        pulse(4'b0001);
        cyc(3);
        chk("R3 no msg while masked", 64'(msg_valid), 0);
        rd_chk("R3 R7 pending set", 16, 1);
        // R6 reads leave state alone
        rd_chk("R6 reread data", 2, 32'h0000_00A0);
        rd_chk("R6 pending kept", 16, 1);

        // R4 unmask captures and sends
        got_data.delete(); got_addr.delete();
        wr(3, 32'hFFFF_FFFE);
        rd_chk("R2 ctrl upper bits zero", 3, 0);
        cyc(3);
        chk("R4 one msg", 64'(got_data.size()), 1);
        if (got_data.size() > 0) begin
            chk("R4 addr", got_addr[0], 64'h1_1000_0000);
            chk("R4 data", 64'(got_data[0]), 64'hA0);
        end
        rd_chk("R7 pending cleared", 16, 0);

        // R5 rewrite while unmasked has no effect on messages
        got_data.delete();
        wr(2, 32'hB0);
        rd_chk("R5 table updated", 2, 32'hB0);
        pulse(4'b0001); cyc(3);
        chk("R5 old data sent", 64'(got_data.size() > 0 ? got_data[0] : 0), 64'hA0);
        wr(3, 1); wr(3, 0);
        got_data.delete();
        pulse(4'b0001); cyc(3);
        chk("R5 new data after remask", 64'(got_data.size() > 0 ? got_data[0] : 0), 64'hB0);

        // R10 repeated unmask write does not recapture
        wr(2, 32'hC0); wr(3, 0);
        got_data.delete();
        pulse(4'b0001); cyc(3);
        chk("R10 no recapture", 64'(got_data.size() > 0 ? got_data[0] : 0), 64'hB0);

        // R8 priority under back-pressure, R9 hold
        for (int v = 1; v < NV; v++) begin
            wr(4 * v, 32'h2000_0000 + v); wr(4 * v + 2, 32'h100 + v); wr(4 * v + 3, 0);
        end
        msg_ready = 0;
        got_data.delete();
        pulse(4'b1111);
        cyc(2);
        @(negedge clk);
        chk("R9 held valid", 64'(msg_valid), 1);
        chk("R8 lowest first", 64'(msg_data), 64'hB0);
        cyc(3);
        @(negedge clk);
        chk("R9 held data", 64'(msg_data), 64'hB0);
        cyc();
        for (int k = 0; k < NV; k++) begin
            msg_ready = 1; cyc(); msg_ready = 0; cyc();
        end
        chk("R8 count", 64'(got_data.size()), 4);
        for (int k = 0; k < NV; k++)
            if (k < got_data.size())
                chk("R8 order", 64'(got_data[k]), k == 0 ? 64'hB0 : 64'(32'h100 + k));

        // R9 no recall after masking
        got_data.delete();
        pulse(4'b0010); cyc(2);
        wr(7, 1);
        cyc();
        msg_ready = 1; cyc(2);
        chk("R9 delivered after mask", 64'(got_data.size() > 0 ? got_data[0] : 0), 64'h101);
        pulse(4'b0010); cyc(3);
        chk("R3 masked after recall test", 64'(msg_valid), 0);
        rd_chk("R3 pending held", 16, 32'h2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule